// File: doc/BRIEF.md
# Branch Predictor Access Gate

This block sits in the fetch stage beside a small, directly indexed fetch cache. For each instruction slot and each fetch group of that cache it keeps two hint bits. The per-group "sequential-clean" bit says that the next sequential fetch group contains no direct conditional branch. The per-instruction "target-clean" bit says that the instruction is a direct transfer and that its target group, from the target slot onward, contains no direct conditional branch. Both bits are filled from a single predecode flag that the first-level instruction cache stores with every instruction. That flag is 1 when the instruction is not a direct conditional branch.

Each fetch step reports where fetch goes next and whether the next fetch is a guaranteed hit in the small cache. The block then decides, one cycle ahead, whether the direction predictor, the target-buffer data array and the target-buffer tag array need to be read. When the next fetch is a guaranteed hit on the target of a direct unconditional jump or call, all three arrays stay off. In that case the block supplies the jump target formed from the instruction field. Two cycles after a fetch ran with the predictor off, a suppress strobe tells the resolve stage not to train the predictor or the target buffer for that fetch. The fetch width (1, 2 or 4) is a parameter, and the hint bits always describe whole fetch groups.

Top module: `bp_access_gate`

## Requirements
- R1: After synchronous reset, predEn, btbDataEn, btbTagEn, jumpSel, jumpTgt and updSuppress are 0, and every hint bit is clear. A guaranteed sequential step that follows reset therefore leaves the predictor enabled.
- R2: A step with stepValid=1, nextGuaranteed=1, nextKind=1 (sequential) and a set sequential-clean bit for curGroup gives predEn=0 and btbDataEn=0 in the next cycle. predEn always equals btbDataEn.
- R3: On a fill of line L, group k of that line (group index L*LINE_W/FETCH_W+k) takes the AND of the predecode bits of group k+1 of the same line. fillNb bit j belongs to instruction slot j of the line. The last group of the filled line is cleared.
- R4: On a fill of line L, the last group of line L-1 (modulo the line count) takes the AND of the predecode bits of the first group of line L when fillSeq=1. When fillSeq=0, that bit is cleared.
- R5: A step with nextGuaranteed=1, nextKind=2 (direct target) and a set target-clean bit for instruction curGroup*FETCH_W+curSlot gives predEn=0 and btbDataEn=0 in the next cycle.
- R6: An update with ntUpdValid=1 sets the target-clean bit of instruction ntUpdIdx to the AND of ntUpdNb over the slots from ntUpdSlot to FETCH_W-1. A fill clears the target-clean bits of every instruction in the filled line, and the fill wins over a same-cycle update to that line.
- R7: A step with nextGuaranteed=1, nextKind=2 and curIsJump=1 gives, in the next cycle, predEn=btbDataEn=btbTagEn=0, jumpSel=1 and jumpTgt={curPcHigh, jumpField}. Without jumpSel, jumpTgt is 0.
- R8: A valid step whose next fetch is not guaranteed, or whose nextKind is 0 or 3, enables predEn, btbDataEn and btbTagEn in the next cycle.
- R9: When the target buffer has at least as many entries as the small cache holds instructions, an ungated guaranteed sequential step with nextNtBit=1 gives btbTagEn=0 while btbDataEn=1. btbTagEn is never 1 while btbDataEn is 0.
- R10: updSuppress is 1 exactly two cycles after a valid step that gated the predictor off.
- R11: A cycle with stepValid=0 gives predEn, btbDataEn, btbTagEn and jumpSel all 0 in the next cycle.
- R12: A step reads the hint bits as they stood before any fill or update applied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fillValid | input | 1 | A line is being written into the small cache |
| fillLine | input | $clog2(NUM_LINES) | Line index of the fill |
| fillSeq | input | 1 | The filled line was reached by sequential fetch |
| fillNb | input | LINE_W | Predecode not-a-conditional-branch flags of the filled line, bit j = slot j |
| ntUpdValid | input | 1 | Write a target-clean bit |
| ntUpdIdx | input | $clog2(LINE_W*NUM_LINES) | Instruction index of the direct transfer |
| ntUpdSlot | input | max(1,$clog2(FETCH_W)) | Slot of the target inside its group |
| ntUpdNb | input | FETCH_W | Predecode flags of the target group |
| stepValid | input | 1 | A fetch step happens this cycle |
| curGroup | input | $clog2(groups) | Small-cache group being fetched |
| curSlot | input | max(1,$clog2(FETCH_W)) | Slot of the last issued instruction (the transfer if taken) |
| nextKind | input | 2 | 0 other, 1 sequential, 2 direct target, 3 treated as other |
| nextGuaranteed | input | 1 | Next fetch is a guaranteed small-cache hit |
| nextNtBit | input | 1 | Next instruction's next-target guarantee bit |
| curIsJump | input | 1 | Current transfer is a direct unconditional jump or call |
| curPcHigh | input | PC_W-JF_W | Upper instruction-address bits kept across a jump |
| jumpField | input | JF_W | Target field of the jump instruction |
| predEn | output | 1 | Direction predictor read enable for the next fetch |
| btbDataEn | output | 1 | Target-buffer data array enable |
| btbTagEn | output | 1 | Target-buffer tag array enable |
| jumpSel | output | 1 | Use jumpTgt as the next fetch address |
| jumpTgt | output | PC_W | Decoded direct-jump target |
| updSuppress | output | 1 | Do not train predictor or target buffer for the fetch two steps back |

## Verification
The bench builds the block with a fetch width of 2, four-instruction lines, four lines and a 16-entry target buffer. With these values every line holds two groups. A fill therefore exercises both the intra-line group shift and the write into the previous line's last group. A nonzero target slot exercises the partial AND of the target-clean bit. The target buffer is as large as the cache, so the tag-skip variant is the one that gets built and reached. Directed steps are followed by a long random mix of fills, hint updates and steps, and all of it is compared against a behavioural model of the hint bits.

// File: rtl/bp_gate_pkg.sv
package bp_gate_pkg;
  typedef enum logic [1:0] {
    NX_OTHER  = 2'd0,
    NX_SEQ    = 2'd1,
    NX_DIRECT = 2'd2,
    NX_RSVD   = 2'd3
  } nextKind_e;

  typedef struct packed {
    logic issue;     // a fetch step happens
    logic gatePred;  // predictor and target-buffer data off
    logic skipTag;   // target-buffer tag compare may be skipped
    logic selJump;   // decoded jump target replaces the prediction
  } gateStrobe_t;
endpackage

// File: rtl/bp_gate_ctrl.sv
module bp_gate_ctrl
  import bp_gate_pkg::*;
#(
  parameter int NUM_INSTR   = 16,
  parameter int BTB_ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stepValid,
  input  logic [1:0]  nextKind,
  input  logic        nextGuaranteed,
  input  logic        nextNtBit,
  input  logic        curIsJump,
  input  logic        nsnbRd,
  input  logic        ntnbRd,
  output gateStrobe_t strobe
);
  nextKind_e kind;
  logic guarSeq, guarDir, jumpHit, gateAny, tagSkipOk;

  assign kind = nextKind_e'(nextKind);

  // Tag skipping is only sound when every cached instruction can own a buffer entry.
  generate
    if (BTB_ENTRIES >= NUM_INSTR) begin : g_tagSkip
      assign tagSkipOk = 1'b1;
    end else begin : g_noTagSkip
      assign tagSkipOk = 1'b0;
    end
  endgenerate

  always_comb begin
    guarSeq = nextGuaranteed && (kind == NX_SEQ);
    guarDir = nextGuaranteed && (kind == NX_DIRECT);
    jumpHit = guarDir && curIsJump;
    gateAny = jumpHit || (guarSeq && nsnbRd) || (guarDir && ntnbRd);
    strobe.issue    = stepValid;
    strobe.gatePred = stepValid && gateAny;
    strobe.selJump  = stepValid && jumpHit;
    strobe.skipTag  = stepValid && guarSeq && nextNtBit && tagSkipOk;
  end

  // R8: an unguaranteed next fetch never gates the predictor
  assert_unguaranteed_open_R8: assert property (@(posedge clk) disable iff (rst)
    (stepValid && !nextGuaranteed) |-> !strobe.gatePred);

  // R7: a jump selection only comes with the arrays gated
  assert_jump_gated_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.selJump |-> strobe.gatePred);
endmodule

// File: rtl/bp_gate_dp.sv
module bp_gate_dp
  import bp_gate_pkg::*;
#(
  parameter int FETCH_W   = 2,
  parameter int LINE_W    = 4,
  parameter int NUM_LINES = 4,
  parameter int PC_W      = 30,
  parameter int JF_W      = 26,
  localparam int NUM_INSTR = LINE_W * NUM_LINES,
  localparam int GPL       = LINE_W / FETCH_W,
  localparam int NUM_GRP   = NUM_LINES * GPL,
  localparam int GIDX_W    = $clog2(NUM_GRP),
  localparam int LIDX_W    = $clog2(NUM_LINES),
  localparam int IIDX_W    = $clog2(NUM_INSTR),
  localparam int SLOT_W    = (FETCH_W > 1) ? $clog2(FETCH_W) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fillValid,
  input  logic [LIDX_W-1:0]      fillLine,
  input  logic                   fillSeq,
  input  logic [LINE_W-1:0]      fillNb,
  input  logic                   ntUpdValid,
  input  logic [IIDX_W-1:0]      ntUpdIdx,
  input  logic [SLOT_W-1:0]      ntUpdSlot,
  input  logic [FETCH_W-1:0]     ntUpdNb,
  input  logic [GIDX_W-1:0]      curGroup,
  input  logic [SLOT_W-1:0]      curSlot,
  input  logic [PC_W-JF_W-1:0]   curPcHigh,
  input  logic [JF_W-1:0]        jumpField,
  input  gateStrobe_t            strobe,
  output logic                   nsnbRd,
  output logic                   ntnbRd,
  output logic                   predEn,
  output logic                   btbDataEn,
  output logic                   btbTagEn,
  output logic                   jumpSel,
  output logic [PC_W-1:0]        jumpTgt,
  output logic                   updSuppress
);
  localparam logic [NUM_INSTR-1:0] LINE_MASK = NUM_INSTR'((1 << LINE_W) - 1);

  logic [NUM_GRP-1:0]   nsnbQ, nsnbN;
  logic [NUM_INSTR-1:0] ntnbQ, ntnbN;
  logic [GPL-1:0]       grpAllNb, fillNsnb;
  logic [IIDX_W-1:0]    curInst;
  logic                 ntVal, gatedQ;

  // Per-group AND of the fill's predecode flags.
  generate
    for (genvar k = 0; k < GPL; k++) begin : g_grpNb
      assign grpAllNb[k] = &fillNb[k*FETCH_W +: FETCH_W];
    end
  endgenerate

  // Each group inherits the flags of the group after it; the last one gets 0.
  assign fillNsnb = GPL'(grpAllNb >> 1);

  always_comb begin
    curInst = IIDX_W'(int'(curGroup) * FETCH_W + ((FETCH_W > 1) ? int'(curSlot) : 0));
    nsnbRd  = nsnbQ[curGroup];
    ntnbRd  = ntnbQ[curInst];
  end

  always_comb begin
    ntVal = 1'b1;
    for (int s = 0; s < FETCH_W; s++) begin
      if (FETCH_W == 1 || s >= int'(ntUpdSlot)) ntVal = ntVal & ntUpdNb[s];
    end
  end

  always_comb begin
    nsnbN = nsnbQ;
    ntnbN = ntnbQ;
    if (ntUpdValid) ntnbN[ntUpdIdx] = ntVal;
    if (fillValid) begin
      nsnbN[GIDX_W'((int'(fillLine) * GPL + NUM_GRP - 1) % NUM_GRP)] = fillSeq & grpAllNb[0];
      for (int k = 0; k < GPL; k++) begin
        nsnbN[GIDX_W'(int'(fillLine) * GPL + k)] = fillNsnb[k];
      end
      for (int i = 0; i < LINE_W; i++) begin
        ntnbN[IIDX_W'(int'(fillLine) * LINE_W + i)] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nsnbQ       <= '0;
      ntnbQ       <= '0;
      predEn      <= 1'b0;
      btbDataEn   <= 1'b0;
      btbTagEn    <= 1'b0;
      jumpSel     <= 1'b0;
      jumpTgt     <= '0;
      gatedQ      <= 1'b0;
      updSuppress <= 1'b0;
    end else begin
      nsnbQ       <= nsnbN;
      ntnbQ       <= ntnbN;
      predEn      <= strobe.issue && !strobe.gatePred;
      btbDataEn   <= strobe.issue && !strobe.gatePred;
      btbTagEn    <= strobe.issue && !strobe.gatePred && !strobe.skipTag;
      jumpSel     <= strobe.selJump;
      jumpTgt     <= strobe.selJump ? {curPcHigh, jumpField} : '0;
      gatedQ      <= strobe.gatePred;
      updSuppress <= gatedQ;
    end
  end

  assert_pred_btb_pair_R2: assert property (@(posedge clk) disable iff (rst)
    predEn == btbDataEn);

  assert_tag_under_data_R9: assert property (@(posedge clk) disable iff (rst)
    btbTagEn |-> btbDataEn);

  assert_jump_arrays_off_R7: assert property (@(posedge clk) disable iff (rst)
    jumpSel |-> (!predEn && !btbTagEn));

  assert_suppress_follows_R10: assert property (@(posedge clk) disable iff (rst)
    gatedQ |=> updSuppress);

  assert_suppress_only_after_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !gatedQ |=> !updSuppress);

  assert_fill_clears_target_R6: assert property (@(posedge clk) disable iff (rst)
    fillValid |=> ((ntnbQ >> (LINE_W * $past(int'(fillLine)))) & LINE_MASK) == '0);

  assert_fill_last_group_R3: assert property (@(posedge clk) disable iff (rst)
    fillValid |=> ((nsnbQ >> ($past(int'(fillLine)) * GPL + GPL - 1)) & NUM_GRP'(1)) == '0);
endmodule

// File: rtl/bp_access_gate.sv
module bp_access_gate
  import bp_gate_pkg::*;
#(
  parameter int FETCH_W     = 2,
  parameter int LINE_W      = 4,
  parameter int NUM_LINES   = 4,
  parameter int BTB_ENTRIES = 16,
  parameter int PC_W        = 30,
  parameter int JF_W        = 26,
  localparam int NUM_INSTR = LINE_W * NUM_LINES,
  localparam int NUM_GRP   = NUM_LINES * (LINE_W / FETCH_W),
  localparam int GIDX_W    = $clog2(NUM_GRP),
  localparam int LIDX_W    = $clog2(NUM_LINES),
  localparam int IIDX_W    = $clog2(NUM_INSTR),
  localparam int SLOT_W    = (FETCH_W > 1) ? $clog2(FETCH_W) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fillValid,
  input  logic [LIDX_W-1:0]    fillLine,
  input  logic                 fillSeq,
  input  logic [LINE_W-1:0]    fillNb,
  input  logic                 ntUpdValid,
  input  logic [IIDX_W-1:0]    ntUpdIdx,
  input  logic [SLOT_W-1:0]    ntUpdSlot,
  input  logic [FETCH_W-1:0]   ntUpdNb,
  input  logic                 stepValid,
  input  logic [GIDX_W-1:0]    curGroup,
  input  logic [SLOT_W-1:0]    curSlot,
  input  logic [1:0]           nextKind,
  input  logic                 nextGuaranteed,
  input  logic                 nextNtBit,
  input  logic                 curIsJump,
  input  logic [PC_W-JF_W-1:0] curPcHigh,
  input  logic [JF_W-1:0]      jumpField,
  output logic                 predEn,
  output logic                 btbDataEn,
  output logic                 btbTagEn,
  output logic                 jumpSel,
  output logic [PC_W-1:0]      jumpTgt,
  output logic                 updSuppress
);
  gateStrobe_t strobe;
  logic nsnbRd, ntnbRd;

  bp_gate_ctrl #(.NUM_INSTR(NUM_INSTR), .BTB_ENTRIES(BTB_ENTRIES)) ctrl_i (
    .clk(clk), .rst(rst), .stepValid(stepValid), .nextKind(nextKind),
    .nextGuaranteed(nextGuaranteed), .nextNtBit(nextNtBit), .curIsJump(curIsJump),
    .nsnbRd(nsnbRd), .ntnbRd(ntnbRd), .strobe(strobe)
  );

  bp_gate_dp #(.FETCH_W(FETCH_W), .LINE_W(LINE_W), .NUM_LINES(NUM_LINES),
               .PC_W(PC_W), .JF_W(JF_W)) dp_i (
    .clk(clk), .rst(rst), .fillValid(fillValid), .fillLine(fillLine), .fillSeq(fillSeq),
    .fillNb(fillNb), .ntUpdValid(ntUpdValid), .ntUpdIdx(ntUpdIdx), .ntUpdSlot(ntUpdSlot),
    .ntUpdNb(ntUpdNb), .curGroup(curGroup), .curSlot(curSlot), .curPcHigh(curPcHigh),
    .jumpField(jumpField), .strobe(strobe), .nsnbRd(nsnbRd), .ntnbRd(ntnbRd),
    .predEn(predEn), .btbDataEn(btbDataEn), .btbTagEn(btbTagEn), .jumpSel(jumpSel),
    .jumpTgt(jumpTgt), .updSuppress(updSuppress)
  );

  // R11: no step, no array access and no jump selection
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !stepValid |=> (!predEn && !btbDataEn && !btbTagEn && !jumpSel));
endmodule

// File: tb/bp_access_gate_tb_top.sv
`timescale 1ns/1ps
module bp_access_gate_tb_top;
  localparam int FW = 2, LW = 4, NL = 4, GPL = 2, NG = 8, NI = 16, PCW = 30, JFW = 26;

  logic clk = 0, rst = 1;
  logic fillValid = 0, fillSeq = 0, ntUpdValid = 0, stepValid = 0;
  logic nextGuaranteed = 0, nextNtBit = 0, curIsJump = 0;
  logic [1:0] fillLine = 0, nextKind = 0;
  logic [3:0] fillNb = 0, ntUpdIdx = 0;
  logic [0:0] ntUpdSlot = 0, curSlot = 0;
  logic [1:0] ntUpdNb = 0;
  logic [2:0] curGroup = 0;
  logic [3:0] curPcHigh = 0;
  logic [JFW-1:0] jumpField = 0;
  logic predEn, btbDataEn, btbTagEn, jumpSel, updSuppress;
  logic [PCW-1:0] jumpTgt;

  always #2 clk = ~clk;

  bp_access_gate dut_i (.*);

  int checks = 0, fails = 0;
  bit nsnbM [NG];
  bit ntnbM [NI];
  bit eP, eD, eT, eJ, eS, pendGate;
  logic [PCW-1:0] eTgt;
  string tagP, tagT;

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(tagP, "predEn", 32'(predEn), 32'(eP));
    chk(tagP, "btbDataEn", 32'(btbDataEn), 32'(eD));
    chk(tagT, "btbTagEn", 32'(btbTagEn), 32'(eT));
    chk("R7", "jumpSel", 32'(jumpSel), 32'(eJ));
    chk("R7", "jumpTgt", 32'(jumpTgt), 32'(eTgt));
    chk("R10", "updSuppress", 32'(updSuppress), 32'(eS));
  endtask

  // Behavioural reference: decides from the hint bits as they stand, then applies writes (R12).
  task automatic modelStep();
    int inst;
    bit gSeq, gDir, jHit, sGate, tGate, gate, v;
    inst  = int'(curGroup) * FW + int'(curSlot);
    gSeq  = nextGuaranteed && nextKind == 2'd1;
    gDir  = nextGuaranteed && nextKind == 2'd2;
    jHit  = gDir && curIsJump;
    sGate = gSeq && nsnbM[curGroup];
    tGate = gDir && ntnbM[inst];
    gate  = jHit || sGate || tGate;
    eP = stepValid && !gate;
    eD = eP;
    eT = eP && !(gSeq && nextNtBit);
    eJ = stepValid && jHit;
    eTgt = eJ ? {curPcHigh, jumpField} : '0;
    eS = pendGate;
    pendGate = stepValid && gate;
    if (!stepValid) tagP = "R11";
    else if (jHit) tagP = "R7";
    else if (sGate) tagP = "R2/R3/R4/R12";
    else if (tGate) tagP = "R5/R6/R12";
    else tagP = "R8/R1";
    tagT = (eP && !eT) ? "R9" : tagP;
    if (ntUpdValid) begin
      v = 1;
      for (int s = int'(ntUpdSlot); s < FW; s++) v = v & ntUpdNb[s];
      ntnbM[ntUpdIdx] = v;
    end
    if (fillValid) begin
      nsnbM[(int'(fillLine) * GPL + NG - 1) % NG] = fillSeq && fillNb[0] && fillNb[1];
      for (int k = 0; k < GPL; k++) begin
        v = (k < GPL - 1);
        if (v) for (int s = 0; s < FW; s++) v = v & fillNb[(k + 1) * FW + s];
        nsnbM[int'(fillLine) * GPL + k] = v;
      end
      for (int i = 0; i < LW; i++) ntnbM[int'(fillLine) * LW + i] = 0;
    end
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleInputs();
    fillValid = 0; ntUpdValid = 0; stepValid = 0; curIsJump = 0;
    nextGuaranteed = 0; nextNtBit = 0; nextKind = 0;
  endtask

  task automatic doStep(logic [2:0] g, logic sl, logic [1:0] k, logic gu, logic nt, logic jmp);
    idleInputs();
    stepValid = 1; curGroup = g; curSlot = sl; nextKind = k;
    nextGuaranteed = gu; nextNtBit = nt; curIsJump = jmp;
    tick();
  endtask

  task automatic doFill(logic [1:0] ln, logic sq, logic [3:0] nb);
    idleInputs();
    fillValid = 1; fillLine = ln; fillSeq = sq; fillNb = nb;
    tick();
  endtask

  task automatic doNt(logic [3:0] idx, logic sl, logic [1:0] nb);
    idleInputs();
    ntUpdValid = 1; ntUpdIdx = idx; ntUpdSlot = sl; ntUpdNb = nb;
    tick();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state of every output
    eP = 0; eD = 0; eT = 0; eJ = 0; eS = 0; eTgt = '0; pendGate = 0;
    tagP = "R1"; tagT = "R1";
    compareAll();
    doStep(3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0);  // R1: cleared hints keep predictor on
    doFill(2'd0, 1'b0, 4'b1111);                 // R3: group 0 clean, group 1 cleared
    doStep(3'd0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);  // R2: gated
    doStep(3'd1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);  // R3: last group not gated
    doFill(2'd1, 1'b1, 4'b0011);                 // R4: sequential fill sets group 1
    doStep(3'd1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    doStep(3'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0);  // R8: not guaranteed
    doFill(2'd1, 1'b0, 4'b1111);                 // R4: non-sequential fill clears group 1
    doStep(3'd1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    doNt(4'd0, 1'b1, 2'b10);                     // R6: partial AND from slot 1
    doStep(3'd0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);  // R5: gated
    doNt(4'd0, 1'b0, 2'b10);                     // R6: slot 0 flag low clears
    doStep(3'd0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
    doNt(4'd1, 1'b0, 2'b11);
    idleInputs();                                // R6: fill wins over same-cycle update
    fillValid = 1; fillLine = 2'd0; fillSeq = 0; fillNb = 4'b0000;
    ntUpdValid = 1; ntUpdIdx = 4'd1; ntUpdSlot = 0; ntUpdNb = 2'b11;
    tick();
    doStep(3'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0);
    curPcHigh = 4'hA; jumpField = 26'h123_4567;
    doStep(3'd2, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1);  // R7: decoded jump target
    doStep(3'd2, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);  // R9: tag skipped
    doStep(3'd2, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0);  // R8: reserved kind
    idleInputs(); tick();                        // R11: idle
    tick();                                      // R10: suppress pipeline drains
    for (int n = 0; n < 4000; n++) begin
      idleInputs();
      stepValid = ($urandom % 5) != 0;
      curGroup = 3'($urandom); curSlot = 1'($urandom);
      nextKind = 2'($urandom); nextGuaranteed = ($urandom % 10) < 7;
      nextNtBit = 1'($urandom); curIsJump = ($urandom % 4) == 0;
      curPcHigh = 4'($urandom); jumpField = JFW'($urandom);
      fillValid = ($urandom % 6) == 0; fillLine = 2'($urandom); fillSeq = 1'($urandom);
      for (int b = 0; b < LW; b++) fillNb[b] = ($urandom % 8) != 0;
      ntUpdValid = ($urandom % 4) == 0; ntUpdIdx = 4'($urandom); ntUpdSlot = 1'($urandom);
      for (int b = 0; b < FW; b++) ntUpdNb[b] = ($urandom % 6) != 0;
      tick();
    end
    finishRun();
  end
endmodule